// File: doc/BRIEF.md
# Multiplierless Interpolated Base-2 Logarithm Unit

The unit takes a positive value split into an unsigned exponent `e` and a 23-bit fractional mantissa `m`. Together they stand for 2^e·(1+m). It returns log2 of that value as a fixed-point number. The integer field is `e` itself. The 16-bit fractional field approximates log2(1+m).

That fraction is built from three parts:
- the mantissa itself;
- a correction read from a 65-entry table of the curve log2(1+m) − m, addressed by the top six mantissa bits;
- a linear step between that entry `a` and its upper neighbour `b`, weighted by the next seven mantissa bits `n`.

The product (b−a)·n is never multiplied out. Each factor is turned into a logarithm by a leading-one detector and a small correction table. The two logarithms are added. The sum is turned back with a small antilogarithm table and a barrel shift. A compare on `b` and `a` picks whether the step is added or subtracted.

The datapath has four register stages, with a valid bit carried beside the data. One shared advance condition moves all four stages at once. The stages move whenever the output register is empty or the consumer takes its contents. Input is a valid/ready handshake, and output is a valid/ready handshake.

Top module: `lg2_interp_unit`

## Requirements
- R1: The integer field `out_int` of every result equals the exponent `in_exp` of the input that produced it, for any exponent value including 0 and the largest.
- R2: `out_frac`, read as an unsigned Q0.16 value, differs from log2(1 + in_man/2^23) by less than 2^-12 for every mantissa, whether the correction curve is rising or falling at that point.
- R3: When the 17 mantissa bits below the top six are all zero, the step term is skipped. `out_frac` is then within one LSB (2^-16) of 65536·log2(1+m).
- R4: For the largest mantissa (all ones), the upper neighbour is taken as 0. The fraction saturates rather than wraps, so `out_frac` is at least 16'hFFF0.
- R5: The seven least significant mantissa bits `in_man[6:0]` have no effect on `out_int` or `out_frac`.
- R6: If a transfer is accepted at clock edge k and `out_ready` stays high, the result shows `out_valid` high right after edge k+3. Back-to-back inputs give one result per cycle, in order.
- R7: While `out_valid` is high and `out_ready` is low, `out_int` and `out_frac` hold their values, `out_valid` stays high, and `in_ready` is low.
- R8: While `rst_n` is low, `out_valid` is low. After release, with nothing in flight, `in_ready` is high.
- R9: Cycles with `in_valid` low produce no result: `out_valid` stays low once the earlier results have drained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operand present |
| in_ready | output | 1 | Unit accepts the operand this cycle |
| in_exp | input | EXP_W | Unsigned exponent e |
| in_man | input | MAN_W | Fractional mantissa m (value m/2^MAN_W) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_int | output | EXP_W | Integer part of the logarithm |
| out_frac | output | 16 | Fractional part of the logarithm, Q0.16, truncated |

## Verification
The assertions watch the handshake on every cycle:
- the fixed four-edge latency under a free-running consumer;
- held outputs and a low `in_ready` during a stall;
- a quiet `out_valid` under reset;
- a bound stating that the rebuilt interpolation product never exceeds the table difference it scales by more than two LSBs.

Numeric accuracy against a real-valued logarithm can only be shown by the bench scenarios. The same holds for exactness at table nodes, saturation at the top of the mantissa range, the insensitivity to the lowest mantissa bits, and the result order in a stream.

// File: rtl/lg2_pkg.sv
package lg2_pkg;

    localparam int LG_T    = 6;              // mantissa bits addressing the segment table
    localparam int LG_K    = 13;             // mantissa bits used by the interpolator
    localparam int LG_NW   = LG_K - LG_T;    // width of the interpolation weight n
    localparam int LG_FW   = 16;             // fractional bits of tables and result
    localparam int LG_DW   = 10;             // width of |b-a|
    localparam int LG_LF   = 10;             // fractional bits in the small log domain
    localparam int LG_LIDX = 6;              // address bits of the small log/antilog tables

    // Fraction of log2(x) for x in [1,2) given as Q30; result is Q20.
    function automatic longint unsigned lg_frac20(input longint unsigned x30);
        longint unsigned y;
        longint unsigned r;
        y = x30;
        r = 0;
        for (int j = 0; j < 20; j++) begin
            y = (y * y) >> 30;
            r = r << 1;
            if (y >= (64'd2 << 30)) begin
                r = r | 64'd1;
                y = y >> 1;
            end
        end
        return r;
    endfunction

    // Segment correction log2(1+i/2^t) - i/2^t, rounded to fw fractional bits.
    function automatic longint unsigned seg_corr(input int i, input int t, input int fw);
        longint unsigned x;
        longint unsigned v;
        if (i >= (1 << t)) return 0;
        x = (64'd1 << 30) + (longint'(i) << (30 - t));
        v = lg_frac20(x) - (longint'(i) << (20 - t));
        return (v + (64'd1 << (20 - fw - 1))) >> (20 - fw);
    endfunction

    // Log correction at the midpoint of slot j: log2(1+f) - f, lf fractional bits.
    function automatic longint unsigned log_corr(input int j, input int lidx, input int lf);
        longint unsigned x;
        longint unsigned f;
        longint unsigned v;
        x = (64'd1 << 30) + (longint'(2 * j + 1) << (30 - lidx - 1));
        f = longint'(2 * j + 1) << (20 - lidx - 1);
        v = lg_frac20(x) - f;
        return (v + (64'd1 << (20 - lf - 1))) >> (20 - lf);
    endfunction

    // Antilog correction at the midpoint of slot j: 1 + g - 2^g, lf fractional bits.
    function automatic longint unsigned exp_corr(input int j, input int lidx, input int lf);
        longint unsigned g;
        longint unsigned lo;
        longint unsigned hi;
        longint unsigned mid;
        longint unsigned v;
        g  = longint'(2 * j + 1) << (20 - lidx - 1);
        lo = 64'd1 << 20;
        hi = 64'd2 << 20;
        for (int s = 0; s < 21; s++) begin
            mid = (lo + hi) >> 1;
            if (lg_frac20(mid << 10) <= g) lo = mid;
            else                           hi = mid;
        end
        v = (64'd1 << 20) + g - lo;
        return (v + (64'd1 << (20 - lf - 1))) >> (20 - lf);
    endfunction

endpackage

// File: rtl/lg2_lod_log.sv
module lg2_lod_log
    import lg2_pkg::*;
#(
    parameter int W    = 10,
    parameter int LF   = 10,
    parameter int LIDX = 6,
    parameter int PW   = $clog2(W) + 1,
    parameter int OW   = PW + LF
) (
    input  logic [W-1:0]  val,
    output logic [OW-1:0] lg
);

    localparam int NE = 2 ** LIDX;

    logic [LF-1:0]   ltab [NE];
    logic [PW-1:0]   pos;
    logic [PW-1:0]   sh;
    logic [W+LF-1:0] norm;
    logic [LF-1:0]   f;

    for (genvar g = 0; g < NE; g++) begin : g_ltab
        assign ltab[g] = LF'(log_corr(g, LIDX, LF));
    end

    always_comb begin
        pos = '0;
        for (int k = 0; k < W; k++) begin
            if (val[k]) pos = PW'(k);
        end
    end

    assign sh   = PW'(W - 1) - pos;
    assign norm = {val, {LF{1'b0}}} << sh;
    assign f    = LF'(norm >> (W - 1));
    assign lg   = OW'({pos, {LF{1'b0}}}) + OW'(f) + OW'(ltab[f[LF-1 -: LIDX]]);

endmodule

// File: rtl/lg2_antilog.sv
module lg2_antilog
    import lg2_pkg::*;
#(
    parameter int QW   = 5,
    parameter int LF   = 10,
    parameter int LIDX = 6,
    parameter int DROP = 7,
    parameter int OW   = 10
) (
    input  logic [QW+LF-1:0] lg,
    output logic [OW-1:0]    val
);

    localparam int NE = 2 ** LIDX;
    localparam int WW = LF + 1 + (2 ** QW) + DROP + OW;

    logic [LF-1:0] etab [NE];
    logic [LF-1:0] g;
    logic [QW-1:0] q;
    logic [LF:0]   mant;
    logic [WW-1:0] wide;

    for (genvar k = 0; k < NE; k++) begin : g_etab
        assign etab[k] = LF'(exp_corr(k, LIDX, LF));
    end

    assign g    = lg[LF-1:0];
    assign q    = lg[QW+LF-1:LF];
    assign mant = {1'b1, g} - (LF+1)'(etab[g[LF-1 -: LIDX]]);
    assign wide = WW'(mant) << q;
    assign val  = OW'(wide >> (LF + DROP));

endmodule

// File: rtl/lg2_interp_unit.sv
module lg2_interp_unit
    import lg2_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [EXP_W-1:0] in_exp,
    input  logic [MAN_W-1:0] in_man,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [EXP_W-1:0] out_int,
    output logic [15:0]      out_frac
);

    localparam int T    = LG_T;
    localparam int K    = LG_K;
    localparam int NW   = LG_NW;
    localparam int FW   = LG_FW;
    localparam int DW   = LG_DW;
    localparam int LF   = LG_LF;
    localparam int LIDX = LG_LIDX;
    localparam int NE   = 2 ** T;
    localparam int OD   = $clog2(DW) + 1 + LF;
    localparam int ON   = $clog2(NW) + 1 + LF;
    localparam int QW   = $clog2(DW + NW);
    localparam int LW   = QW + LF;
    localparam int SW   = FW + 3;

    logic adv;

    // segment table, read at two adjacent addresses
    logic [FW-1:0] seg_rom [NE+1];
    for (genvar g = 0; g <= NE; g++) begin : g_seg
        assign seg_rom[g] = FW'(seg_corr(g, T, FW));
    end

    logic [T-1:0]  idx_lo;
    logic [T:0]    idx_hi;
    logic [FW-1:0] rd_a;
    logic [FW-1:0] rd_b;

    assign idx_lo = T'(in_man >> (MAN_W - T));
    assign idx_hi = {1'b0, idx_lo} + (T+1)'(1);
    assign rd_a   = seg_rom[idx_lo];
    assign rd_b   = seg_rom[idx_hi];

    // stage 1: operands, neighbours and weight
    logic             s1_v;
    logic [EXP_W-1:0] s1_e;
    logic [FW-1:0]    s1_mhi;
    logic [FW-1:0]    s1_a;
    logic [FW-1:0]    s1_b;
    logic [NW-1:0]    s1_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_e   <= '0;
            s1_mhi <= '0;
            s1_a   <= '0;
            s1_b   <= '0;
            s1_n   <= '0;
        end else if (adv) begin
            s1_v   <= in_valid;
            s1_e   <= in_exp;
            s1_mhi <= FW'(in_man >> (MAN_W - FW));
            s1_a   <= rd_a;
            s1_b   <= rd_b;
            s1_n   <= NW'(in_man >> (MAN_W - K));
        end
    end

    // stage 2: compare, magnitude, both logarithms
    logic          c2_neg;
    logic [FW-1:0] c2_diff;
    logic [DW-1:0] c2_absd;
    logic          c2_skip;
    logic [OD-1:0] c2_lgd;
    logic [ON-1:0] c2_lgn;

    assign c2_neg  = s1_b < s1_a;
    assign c2_diff = c2_neg ? (s1_a - s1_b) : (s1_b - s1_a);
    assign c2_absd = DW'(c2_diff);
    assign c2_skip = (c2_absd == '0) || (s1_n == '0);

    lg2_lod_log #(.W(DW), .LF(LF), .LIDX(LIDX), .OW(OD)) u_log_d (
        .val (c2_absd),
        .lg  (c2_lgd)
    );

    lg2_lod_log #(.W(NW), .LF(LF), .LIDX(LIDX), .OW(ON)) u_log_n (
        .val (s1_n),
        .lg  (c2_lgn)
    );

    logic             s2_v;
    logic [EXP_W-1:0] s2_e;
    logic [FW:0]      s2_base;
    logic             s2_neg;
    logic             s2_skip;
    logic [DW-1:0]    s2_absd;
    logic [LW-1:0]    s2_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_e    <= '0;
            s2_base <= '0;
            s2_neg  <= 1'b0;
            s2_skip <= 1'b1;
            s2_absd <= '0;
            s2_l    <= '0;
        end else if (adv) begin
            s2_v    <= s1_v;
            s2_e    <= s1_e;
            s2_base <= (FW+1)'(s1_mhi) + (FW+1)'(s1_a);
            s2_neg  <= c2_neg;
            s2_skip <= c2_skip;
            s2_absd <= c2_absd;
            s2_l    <= LW'(c2_lgd) + LW'(c2_lgn);
        end
    end

    // stage 3: antilog of the summed logarithms
    logic [DW-1:0] c3_term;

    lg2_antilog #(.QW(QW), .LF(LF), .LIDX(LIDX), .DROP(NW), .OW(DW)) u_alog (
        .lg  (s2_l),
        .val (c3_term)
    );

    logic             s3_v;
    logic [EXP_W-1:0] s3_e;
    logic [FW:0]      s3_base;
    logic             s3_neg;
    logic [DW-1:0]    s3_absd;
    logic [DW-1:0]    s3_term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s3_v    <= 1'b0;
            s3_e    <= '0;
            s3_base <= '0;
            s3_neg  <= 1'b0;
            s3_absd <= '0;
            s3_term <= '0;
        end else if (adv) begin
            s3_v    <= s2_v;
            s3_e    <= s2_e;
            s3_base <= s2_base;
            s3_neg  <= s2_neg;
            s3_absd <= s2_absd;
            s3_term <= s2_skip ? '0 : c3_term;
        end
    end

    // stage 4: add or subtract, clamp to the Q0.16 range
    logic signed [SW-1:0] c4_sum;
    logic [FW-1:0]        c4_frac;

    always_comb begin
        if (s3_neg)
            c4_sum = $signed({2'b00, s3_base}) - $signed({{(SW-DW){1'b0}}, s3_term});
        else
            c4_sum = $signed({2'b00, s3_base}) + $signed({{(SW-DW){1'b0}}, s3_term});
        if (c4_sum < 0)
            c4_frac = '0;
        else if (c4_sum > $signed(SW'({FW{1'b1}})))
            c4_frac = '1;
        else
            c4_frac = FW'(c4_sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_int   <= '0;
            out_frac  <= '0;
        end else if (adv) begin
            out_valid <= s3_v;
            out_int   <= s3_e;
            out_frac  <= c4_frac;
        end
    end

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

endmodule

// File: rtl/lg2_interp_chk.sv
module lg2_interp_chk
    import lg2_pkg::*;
#(
    parameter int EXP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [EXP_W-1:0] out_int,
    input logic [15:0]      out_frac,
    input logic             s3_v,
    input logic [LG_DW-1:0] s3_absd,
    input logic [LG_DW-1:0] s3_term
);

    // R6: fixed latency while the consumer keeps taking results
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 out_ready ##1 out_ready ##1 out_ready |=> out_valid);

    // R7: a stalled result stays put
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_int) && $stable(out_frac)));

    // R7: no intake while stalled
    a_r7_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R2: rebuilt product stays within the difference it scales
    a_r2_term_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s3_v |-> ({1'b0, s3_term} <= {1'b0, s3_absd} + (LG_DW+1)'(2)));

    // R8: no result while in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r8_reset_quiet: assert (!out_valid);
        end
    end

endmodule

bind lg2_interp_unit lg2_interp_chk #(.EXP_W(EXP_W)) u_lg2_interp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_int   (out_int),
    .out_frac  (out_frac),
    .s3_v      (s3_v),
    .s3_absd   (s3_absd),
    .s3_term   (s3_term)
);

// File: tb/test_lg2_interp_unit.sv
module test_lg2_interp_unit;

    localparam int CLK_PERIOD = 10;
    localparam int EW = 8;
    localparam int MW = 23;
    localparam int NS = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [EW-1:0] in_exp = '0;
    logic [MW-1:0] in_man = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [EW-1:0] out_int;
    logic [15:0]   out_frac;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lg2_interp_unit #(.EXP_W(EW), .MAN_W(MW)) i_lg2_interp_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_exp    (in_exp),
        .in_man    (in_man),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_int   (out_int),
        .out_frac  (out_frac)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%f expected=%f", req, what, act, exp);
        end
    endtask

    function automatic real ref_log(input logic [MW-1:0] m);
        return $ln(1.0 + real'(m) / 8388608.0) / $ln(2.0);
    endfunction

    task automatic check_acc(input string req, input logic [EW-1:0] e, input logic [MW-1:0] m,
                             input logic [EW-1:0] oi, input logic [15:0] of);
        real r;
        real got;
        r   = ref_log(m);
        got = real'(of) / 65536.0;
        chk(oi == e, "R1", "integer field", real'(oi), real'(e));
        chk((got - r < 1.0 / 4096.0) && (r - got < 1.0 / 4096.0), req, "fraction", got, r);
    endtask

    task automatic send_one(input logic [EW-1:0] e, input logic [MW-1:0] m, output int lat,
                            output logic [EW-1:0] oi, output logic [15:0] of);
        @(negedge clk);
        in_valid = 1'b1;
        in_exp   = e;
        in_man   = m;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid) begin
            @(posedge clk);
            #1;
            lat++;
        end
        oi = out_int;
        of = out_frac;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R8", "out_valid in reset", real'(out_valid), 0.0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(in_ready == 1'b1, "R8", "in_ready after reset", real'(in_ready), 1.0);
        chk(out_valid == 1'b0, "R8", "out_valid after reset", real'(out_valid), 0.0);
    endtask

    task automatic t_nodes();
        int lat;
        logic [EW-1:0] oi;
        logic [15:0] of;
        int idx [5] = '{0, 1, 17, 40, 63};
        foreach (idx[p]) begin
            logic [MW-1:0] m;
            real exact;
            m = MW'(idx[p]) << 17;
            send_one(8'd5, m, lat, oi, of);
            exact = 65536.0 * ref_log(m);
            chk((real'(of) - exact <= 1.0) && (exact - real'(of) <= 1.0), "R3",
                "node fraction", real'(of), exact);
            chk(lat == 4, "R6", "latency", real'(lat), 4.0);
        end
    endtask

    task automatic t_sweep();
        int lat;
        logic [EW-1:0] oi;
        logic [15:0] of;
        logic [MW-1:0] ms [8] = '{23'h000001, 23'h0A5A5A, 23'h1FFFFF, 23'h2C0F00,
                                   23'h3B3B3B, 23'h4E1234, 23'h6789AB, 23'h7C0001};
        logic [EW-1:0] es [4] = '{8'd0, 8'd1, 8'd127, 8'd255};
        foreach (ms[p]) begin
            send_one(es[p % 4], ms[p], lat, oi, of);
            check_acc("R2", es[p % 4], ms[p], oi, of);
        end
    endtask

    task automatic t_top();
        int lat;
        logic [EW-1:0] oi;
        logic [15:0] of;
        send_one(8'd3, 23'h7FFFFF, lat, oi, of);
        chk(of >= 16'hFFF0, "R4", "top of range no wrap", real'(of), 65520.0);
        check_acc("R4", 8'd3, 23'h7FFFFF, oi, of);
    endtask

    task automatic t_lowbits();
        int lat;
        logic [EW-1:0] oi0;
        logic [EW-1:0] oi1;
        logic [15:0] of0;
        logic [15:0] of1;
        logic [MW-1:0] ms [3] = '{23'h123400, 23'h555500, 23'h7AB000};
        foreach (ms[p]) begin
            send_one(8'd9, ms[p], lat, oi0, of0);
            send_one(8'd9, ms[p] | 23'h00007F, lat, oi1, of1);
            chk((of0 == of1) && (oi0 == oi1), "R5", "low bits ignored", real'(of1), real'(of0));
        end
    endtask

    task automatic t_stream();
        logic [MW-1:0] ms [NS];
        logic [EW-1:0] es [NS];
        int first_cyc = -1;
        int last_cyc = -1;
        int got = 0;
        int seed = 32'h1357;
        for (int k = 0; k < NS; k++) begin
            seed = seed * 1103515245 + 12345;
            ms[k] = MW'(seed >>> 3);
            es[k] = EW'(k * 7);
        end
        fork
            begin
                for (int k = 0; k < NS; k++) begin
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_exp   = es[k];
                    in_man   = ms[k];
                end
                @(negedge clk);
                in_valid = 1'b0;
            end
            begin
                for (int cyc = 0; cyc < NS + 10; cyc++) begin
                    @(posedge clk);
                    #1;
                    if (out_valid && got < NS) begin
                        if (first_cyc < 0) first_cyc = cyc;
                        last_cyc = cyc;
                        check_acc("R6", es[got], ms[got], out_int, out_frac);
                        got++;
                    end
                end
            end
        join
        chk(got == NS, "R6", "stream result count", real'(got), real'(NS));
        chk(first_cyc == 3, "R6", "stream first result edge", real'(first_cyc), 3.0);
        chk(last_cyc - first_cyc == NS - 1, "R6", "one result per cycle",
            real'(last_cyc - first_cyc), real'(NS - 1));
    endtask

    task automatic t_backpressure();
        logic [15:0] held;
        logic [EW-1:0] held_i;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_exp    = 8'd20;
        in_man    = 23'h300000;
        @(negedge clk);
        in_exp    = 8'd21;
        in_man    = 23'h650000;
        @(negedge clk);
        in_valid  = 1'b0;
        while (!out_valid) begin
            @(posedge clk);
            #1;
        end
        held   = out_frac;
        held_i = out_int;
        check_acc("R7", 8'd20, 23'h300000, held_i, held);
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            #1;
            chk(out_valid && out_frac == held && out_int == held_i, "R7", "held result",
                real'(out_frac), real'(held));
            chk(in_ready == 1'b0, "R7", "in_ready while stalled", real'(in_ready), 0.0);
        end
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk);
        #1;
        chk(out_valid == 1'b1, "R7", "second result after release", real'(out_valid), 1.0);
        check_acc("R7", 8'd21, 23'h650000, out_int, out_frac);
        @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R7", "drained", real'(out_valid), 0.0);
    endtask

    task automatic t_idle();
        int seen = 0;
        @(negedge clk);
        in_valid = 1'b0;
        in_man   = 23'h7FFFFF;
        for (int c = 0; c < 10; c++) begin
            @(posedge clk);
            #1;
            if (out_valid) seen++;
        end
        chk(seen == 0, "R9", "no result without input", real'(seen), 0.0);
    endtask

    initial begin
        t_reset();
        t_nodes();
        t_sweep();
        t_top();
        t_lowbits();
        t_stream();
        t_backpressure();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule